// File: doc/BRIEF.md
# Hot-plug detect interrupt controller

This block watches the hot-plug-detect line of a display transmitter and turns it into a clean connection state and a single interrupt. The raw line first passes through a two-flop synchronizer. A digital filter then accepts a new level only after the line has held that level for a programmed number of sample ticks. A prescale field sets the spacing of those ticks. A rising filtered level marks a sink being connected, and a falling filtered level marks it being removed.

Each edge latches its own sticky status bit. A third status bit latches the interrupt of the neighbouring transmitter core. Software clears status bits by writing ones to a separate clear register. An active-high enable register chooses which status bits drive the single interrupt output. All registers sit behind a simple single-cycle register port, and reads return data combinationally for the address presented.

Register addresses, as word indices: 0 status, 1 clear, 2 enable, 3 filter, 4 level. Status, clear and enable all use the same bit layout: bit 0 is the core interrupt, bit 1 is the rise event and bit 2 is the fall event. The filter register holds the prescale in bits [15:12] and the stable count in bits [7:0]. The level register shows the filtered line state in bit 0.

Top module: `hpd_irq_ctrl`

## Requirements
- R1: After reset, status, enable and level read 0 and the interrupt output is low. The filter register reads 0x0000A0A0 (prescale 0xA, stable count 0xA0).
- R2: A pulse on the hot-plug line that is shorter than the filter window leaves the level register at 0 and sets no status bit.
- R3: Sample ticks occur every prescale+1 clocks. The level register bit 0 takes the new line value only after the synchronized line has differed from it on stable-count consecutive ticks; a stable count of 0 acts as 1.
- R4: A filtered 0-to-1 change sets status bit 1, and a filtered 1-to-0 change sets status bit 2. Both bits stay set until cleared, and both can be set at the same time.
- R5: A high core-interrupt input on a clock edge sets status bit 0, and that bit stays set after the input falls.
- R6: Writing to the clear register clears each status bit whose data bit is 1. Bits written as 0 are unchanged.
- R7: If a status bit is set by its source in the same cycle that a clear write targets it, the bit stays set.
- R8: The interrupt output is high exactly when some status bit and its enable bit are both 1. A status bit that is not enabled still reads as set.
- R9: Writes to the filter register update the prescale from bits [15:12] and the stable count from bits [7:0], and the register reads back the written fields.
- R10: Writes to the status and level addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_in | input | 1 | Raw hot-plug-detect line, asynchronous |
| core_irq_in | input | 1 | Interrupt from the neighbouring transmitter core |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | 1 | Combined enabled interrupt |

## Verification
The bench sends the filter a glitch shorter than its window. A filter that lacks a restart, or counts clocks instead of ticks, would flip the level and raise a false rise event. It samples the level just before the earliest legal change and again after the latest one, so an off-by-one in the tick or stable count shows up as an early or late change.

It clears the core bit while the core interrupt is still asserted. A design where the clear wins would lose that event. It also writes zero bits to the clear register and writes to the read-only addresses, which would wipe or corrupt status in a careless decode.

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl #(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int PW = 4,
  parameter int SW = 8,
  parameter logic [PW-1:0] PRESC_RST = 4'hA,
  parameter logic [SW-1:0] STAB_RST  = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hpd_in,
  input  logic          core_irq_in,
  input  logic          reg_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_out
);
  localparam int PRESC_LSB = 12;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_CLR  = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_FILT = AW'(3);
  localparam logic [AW-1:0] A_LVL  = AW'(4);

  logic [1:0]    sync;
  logic [PW-1:0] presc_cfg, pcnt;
  logic [SW-1:0] stab_cfg, stab;
  logic          level;
  logic [2:0]    stat, mask;

  wire hpd_s = sync[1];
  wire tick  = (pcnt >= presc_cfg);
  wire [SW:0] limit = (stab_cfg == '0) ? (SW+1)'(1) : {1'b0, stab_cfg};
  wire flip    = tick && (hpd_s != level) && (({1'b0, stab} + 1'b1) >= limit);
  wire rise_ev = flip && hpd_s;
  wire fall_ev = flip && !hpd_s;
  wire wr      = reg_en && reg_wr;
  wire [2:0] clr = (wr && reg_addr == A_CLR) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], hpd_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     pcnt <= '0;
    else if (tick)  pcnt <= '0;
    else            pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stab  <= '0;
      level <= 1'b0;
    end else if (hpd_s == level) begin
      stab <= '0;
    end else if (flip) begin
      stab  <= '0;
      level <= hpd_s;
    end else if (tick) begin
      stab <= stab + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat <= 3'b000;
    else        stat <= (stat & ~clr) | {fall_ev, rise_ev, core_irq_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask      <= 3'b000;
      presc_cfg <= PRESC_RST;
      stab_cfg  <= STAB_RST;
    end else if (wr) begin
      if (reg_addr == A_MASK) mask <= reg_wdata[2:0];
      if (reg_addr == A_FILT) begin
        presc_cfg <= reg_wdata[PRESC_LSB +: PW];
        stab_cfg  <= reg_wdata[SW-1:0];
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata[2:0] = stat;
      A_MASK: reg_rdata[2:0] = mask;
      A_FILT: begin
        reg_rdata[PRESC_LSB +: PW] = presc_cfg;
        reg_rdata[SW-1:0]          = stab_cfg;
      end
      A_LVL:  reg_rdata[0] = level;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_out = |(stat & mask);

  // R3
  level_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(tick) && level == $past(hpd_s)));

  // R4
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |-> stat[1]);

  // R5
  core_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq_in |=> stat[0]);

  // R6
  clear_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_addr == A_CLR && reg_wdata[1] && !rise_ev) |=> !stat[1]);

  // R8
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b000) |-> !irq_out);
endmodule

// File: tb/hpd_irq_ctrl_tb.sv
module hpd_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hpd_in = 1'b0;
  logic        core_irq_in = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hpd_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hpd_in(hpd_in), .core_irq_in(core_irq_in),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    #1;
    check(req, {31'd0, irq_out}, {31'd0, exp});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 status", 3'd0, 32'h0);
    rd_chk("R1 enable", 3'd2, 32'h0);
    rd_chk("R1 filter", 3'd3, 32'h0000A0A0);
    rd_chk("R1 level",  3'd4, 32'h0);
    irq_chk("R1 irq", 1'b0);
  endtask

  task automatic t_config;
    wr_reg(3'd3, 32'hFFFF_1004);
    rd_chk("R9 filter readback", 3'd3, 32'h0000_1004);
    wr_reg(3'd0, 32'h7);
    rd_chk("R10 status write ignored", 3'd0, 32'h0);
    wr_reg(3'd4, 32'h1);
    rd_chk("R10 level write ignored", 3'd4, 32'h0);
    irq_chk("R10 irq low", 1'b0);
  endtask

  task automatic t_glitch;
    @(negedge clk); hpd_in = 1'b1;
    wait_cyc(4);
    hpd_in = 1'b0;
    wait_cyc(20);
    rd_chk("R2 level after glitch", 3'd4, 32'h0);
    rd_chk("R2 status after glitch", 3'd0, 32'h0);
  endtask

  task automatic t_rise;
    @(negedge clk); hpd_in = 1'b1;
    wait_cyc(5);
    rd_chk("R3 level before window", 3'd4, 32'h0);
    wait_cyc(5);
    rd_chk("R3 level after window", 3'd4, 32'h1);
    rd_chk("R4 rise status", 3'd0, 32'h2);
    irq_chk("R8 masked rise", 1'b0);
    wr_reg(3'd2, 32'h2);
    irq_chk("R8 enabled rise", 1'b1);
    wr_reg(3'd1, 32'h0);
    rd_chk("R6 zero clear keeps", 3'd0, 32'h2);
    wr_reg(3'd1, 32'h2);
    rd_chk("R6 clear rise", 3'd0, 32'h0);
    irq_chk("R8 irq after clear", 1'b0);
  endtask

  task automatic t_fall;
    @(negedge clk); hpd_in = 1'b0;
    wait_cyc(14);
    rd_chk("R3 level fell", 3'd4, 32'h0);
    rd_chk("R4 fall status", 3'd0, 32'h4);
    wr_reg(3'd1, 32'h4);
    rd_chk("R6 clear fall", 3'd0, 32'h0);
  endtask

  task automatic t_core;
    @(negedge clk); core_irq_in = 1'b1;
    @(negedge clk); core_irq_in = 1'b0;
    rd_chk("R5 core sticky", 3'd0, 32'h1);
    wr_reg(3'd2, 32'h1);
    irq_chk("R8 core enabled", 1'b1);
    @(negedge clk); core_irq_in = 1'b1;
    wr_reg(3'd1, 32'h1);
    rd_chk("R7 set wins", 3'd0, 32'h1);
    core_irq_in = 1'b0;
    wr_reg(3'd1, 32'h1);
    rd_chk("R6 core cleared", 3'd0, 32'h0);
    irq_chk("R8 core irq low", 1'b0);
  endtask

  task automatic t_both;
    wr_reg(3'd2, 32'h6);
    @(negedge clk); hpd_in = 1'b1;
    wait_cyc(14);
    hpd_in = 1'b0;
    wait_cyc(14);
    rd_chk("R4 both sticky", 3'd0, 32'h6);
    irq_chk("R8 both irq", 1'b1);
    wr_reg(3'd3, 32'h0000_0000);
    @(negedge clk); hpd_in = 1'b1;
    wait_cyc(4);
    rd_chk("R3 zero count acts as one", 3'd4, 32'h1);
    wr_reg(3'd1, 32'h7);
    rd_chk("R6 clear all", 3'd0, 32'h0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset;
    t_config;
    t_glitch;
    t_rise;
    t_fall;
    t_core;
    t_both;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule